// File: doc/BRIEF.md
# Sticky Flash Status Register

This block keeps the 8-bit status word that host software polls to follow flash program and erase operations. The algorithm engine and the command decoder send it single-cycle event pulses. The engine's events are start, done, suspend taken, erase failure, program failure and VPP found absent. The decoder's events are resume and the clear-status command. The block turns these pulses into status bits. Some bits follow the engine: the ready flag and the erase-suspended flag. The error bits stay set until the clear command or a reset.

The block presents two copies of the word. `stat_live` is the register itself. `stat_rd` goes to the read mux and is frozen for the length of a read access. A read access is active while both active-low enables `cs_n` and `rd_n` are low. On the first clock of an access, `stat_rd` captures the live word and then holds it. It only picks up new values after either enable goes high and the access starts again.

Top module: `flash_stat_reg`

## Requirements
- R1: A synchronous active-high reset forces both `stat_live` and `stat_rd` to 80h (ready, not suspended, no errors).
- R2: Bit 7 is the ready flag. `eng_start` clears it and `eng_done` sets it. If both pulse in the same cycle, `eng_start` wins.
- R3: Bit 6 is the erase-suspended flag. `susp_ack` sets bits 6 and 7. `resume` clears bits 6 and 7. If both pulse in the same cycle, `susp_ack` wins. Either one overrides `eng_start`/`eng_done` for bit 7.
- R4: `erase_fail` sets bit 5, `prog_fail` sets bit 4 and `vpp_low` sets bit 3. These bits are not changed by start, done, suspend or resume events.
- R5: `clr_cmd` clears bits 5 to 3 and leaves bits 7 and 6 unchanged. A set pulse for one of those bits in the same cycle wins over the clear.
- R6: Bits 2 to 0 always read 0 on both outputs.
- R7: While no read access is active, and also on the first clock edge at which one is, `stat_rd` takes the value `stat_live` held just before that edge. So it lags `stat_live` by one cycle.
- R8: During an access that lasts more than one clock, `stat_rd` keeps the value captured on its first edge, whatever `stat_live` does. Raising `cs_n` or `rd_n` ends the access, and the next access captures a fresh value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eng_start | input | 1 | Engine starts a program or erase |
| eng_done | input | 1 | Engine finished its operation |
| susp_ack | input | 1 | Erase suspend has taken effect |
| resume | input | 1 | Erase resume issued |
| erase_fail | input | 1 | Erase failed verification after maximum attempts |
| prog_fail | input | 1 | Program failed verification after maximum attempts |
| vpp_low | input | 1 | VPP sample after confirm found no program voltage |
| clr_cmd | input | 1 | Clear-status command decoded |
| cs_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Output enable, active low |
| stat_live | output | 8 | Current status word |
| stat_rd | output | 8 | Status word for the read mux, frozen during an access |

## Verification
The bench builds the block with its fixed layout: an 8-bit word, three reserved zero bits and a reset word of 80h. This layout makes every bit field reachable. Directed sequences cover the collision cases one at a time: start with done, suspend with resume, clear with a set, and suspend overriding start. Randomised event and enable traffic then keeps live status changes landing in the middle of long read accesses and across toggles of each enable on its own.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int RSVD_W  = 3;

    typedef struct packed {
        logic              ready;
        logic              esusp;
        logic              efail;
        logic              pfail;
        logic              vppl;
        logic [RSVD_W-1:0] rsvd;
    } stat_t;

    typedef struct packed {
        logic start;
        logic done;
        logic susp;
        logic resume;
        logic efail;
        logic pfail;
        logic vppl;
        logic clr;
    } stat_ev_t;

    localparam stat_t STAT_RESET = '{ready: 1'b1, esusp: 1'b0, efail: 1'b0,
                                     pfail: 1'b0, vppl: 1'b0, rsvd: '0};

    // Engine-driven bits: start/done first, suspend/resume override.
    function automatic stat_t apply_engine(stat_t s, stat_ev_t e);
        stat_t n = s;
        if (e.start)       n.ready = 1'b0;
        else if (e.done)   n.ready = 1'b1;
        if (e.susp) begin
            n.esusp = 1'b1;
            n.ready = 1'b1;
        end else if (e.resume) begin
            n.esusp = 1'b0;
            n.ready = 1'b0;
        end
        return n;
    endfunction

    // Sticky error bits: clear first, fresh sets win.
    function automatic stat_t apply_sticky(stat_t s, stat_ev_t e);
        stat_t n = s;
        if (e.clr) begin
            n.efail = 1'b0;
            n.pfail = 1'b0;
            n.vppl  = 1'b0;
        end
        if (e.efail) n.efail = 1'b1;
        if (e.pfail) n.pfail = 1'b1;
        if (e.vppl)  n.vppl  = 1'b1;
        n.rsvd = '0;
        return n;
    endfunction

endpackage

// File: rtl/flash_stat_bits.sv
module flash_stat_bits
    import flash_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  stat_ev_t ev,
    output stat_t    stat
);

    stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= STAT_RESET;
        else     stat_q <= apply_sticky(apply_engine(stat_q, ev), ev);
    end

    assign stat = stat_q;

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.susp) |=> !stat_q.ready);

    a_r3_suspend_ready: assert property (@(posedge clk) disable iff (rst)
        ev.susp |=> (stat_q.esusp && stat_q.ready));

    a_r3_resume_clears: assert property (@(posedge clk) disable iff (rst)
        (ev.resume && !ev.susp) |=> (!stat_q.esusp && !stat_q.ready));

    a_r4_efail_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q.efail && !ev.clr) |=> stat_q.efail);

    a_r4_pfail_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q.pfail && !ev.clr) |=> stat_q.pfail);

    a_r5_clear_errors: assert property (@(posedge clk) disable iff (rst)
        (ev.clr && !ev.efail && !ev.pfail && !ev.vppl)
            |=> (!stat_q.efail && !stat_q.pfail && !stat_q.vppl));

    a_r5_clear_keeps_engine: assert property (@(posedge clk) disable iff (rst)
        (ev.clr && !ev.start && !ev.done && !ev.susp && !ev.resume)
            |=> ($stable(stat_q.ready) && $stable(stat_q.esusp)));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q.rsvd == '0));

endmodule

// File: rtl/flash_stat_snap.sv
module flash_stat_snap
    import flash_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  rd_n,
    input  stat_t live,
    output stat_t snap
);

    logic  rd_act;
    logic  rd_act_q;
    stat_t snap_q;

    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            snap_q   <= STAT_RESET;
        end else begin
            rd_act_q <= rd_act;
            if (!rd_act_q) snap_q <= live;
        end
    end

    assign snap = snap_q;

    a_r8_hold_in_access: assert property (@(posedge clk) disable iff (rst)
        (rd_act && rd_act_q) |=> $stable(snap_q));

    a_r7_track_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_act_q |=> (snap_q == $past(live)));

endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_start,
    input  logic              eng_done,
    input  logic              susp_ack,
    input  logic              resume,
    input  logic              erase_fail,
    input  logic              prog_fail,
    input  logic              vpp_low,
    input  logic              clr_cmd,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [STAT_W-1:0] stat_live,
    output logic [STAT_W-1:0] stat_rd
);

    stat_ev_t ev;
    stat_t    live_s;
    stat_t    snap_s;

    assign ev = '{start: eng_start, done: eng_done, susp: susp_ack,
                  resume: resume, efail: erase_fail, pfail: prog_fail,
                  vppl: vpp_low, clr: clr_cmd};

    flash_stat_bits u_bits (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .stat (live_s)
    );

    flash_stat_snap u_snap (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .rd_n (rd_n),
        .live (live_s),
        .snap (snap_s)
    );

    assign stat_live = live_s;
    assign stat_rd   = snap_s;

    a_r1_reset_word: assert property (@(posedge clk)
        rst |=> (stat_live == 8'h80 && stat_rd == 8'h80));

endmodule

// File: tb/tb_flash_stat_reg.sv
module tb_flash_stat_reg;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eng_start = 0, eng_done = 0, susp_ack = 0, resume = 0;
    logic erase_fail = 0, prog_fail = 0, vpp_low = 0, clr_cmd = 0;
    logic cs_n = 1, rd_n = 1;
    logic [7:0] stat_live, stat_rd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_f = 0;

    // behavioural reference
    bit [7:0] m_live = 8'h80;
    bit [7:0] m_snap = 8'h80;
    bit       m_rdq  = 0;

    always #2.5 clk = ~clk;

    flash_stat_reg dut (
        .clk(clk), .rst(rst), .eng_start(eng_start), .eng_done(eng_done),
        .susp_ack(susp_ack), .resume(resume), .erase_fail(erase_fail),
        .prog_fail(prog_fail), .vpp_low(vpp_low), .clr_cmd(clr_cmd),
        .cs_n(cs_n), .rd_n(rd_n), .stat_live(stat_live), .stat_rd(stat_rd)
    );

    always @(posedge clk) begin
        bit [7:0] n;
        cyc++;
        if (rst) begin
            m_live <= 8'h80; m_snap <= 8'h80; m_rdq <= 0;
        end else begin
            n = m_live;
            if (eng_start) n[7] = 0;
            else if (eng_done) n[7] = 1;
            if (susp_ack) begin n[7] = 1; n[6] = 1; end
            else if (resume) begin n[7] = 0; n[6] = 0; end
            if (clr_cmd) n[5:3] = 3'b000;
            if (erase_fail) n[5] = 1;
            if (prog_fail)  n[4] = 1;
            if (vpp_low)    n[3] = 1;
            if (!m_rdq) m_snap <= m_live;
            m_rdq  <= !cs_n && !rd_n;
            m_live <= n;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %02h expected %02h", tag, cyc, act, exp);
        end
    endtask

    // compare every clock, at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 ready bit", {7'b0, stat_live[7]}, {7'b0, m_live[7]});
            chk("R3 suspend bit", {7'b0, stat_live[6]}, {7'b0, m_live[6]});
            chk("R4 R5 error bits", {5'b0, stat_live[5:3]}, {5'b0, m_live[5:3]});
            chk("R6 reserved bits", {5'b0, stat_live[2:0] | stat_rd[2:0]}, 8'h00);
            if (m_rdq) chk("R8 frozen read", stat_rd, m_snap);
            else       chk("R7 tracking read", stat_rd, m_snap);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
        {eng_start, eng_done, susp_ack, resume, erase_fail, prog_fail, vpp_low, clr_cmd} = '0;
    endtask

    task automatic pulse(ref logic s);
        s = 1; step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1 reset live", stat_live, 8'h80);
        chk("R1 reset read", stat_rd, 8'h80);
        @(posedge clk); #1;
        rst = 0;
        step(2);
        // R2
        pulse(eng_start); step(2);
        pulse(eng_done);  step();
        eng_start = 1; eng_done = 1; step(2);
        pulse(eng_done);
        // R4 error sets and stickiness
        pulse(erase_fail); pulse(prog_fail); pulse(vpp_low);
        pulse(eng_start); pulse(eng_done);
        // R5 clear, and set beats clear
        pulse(clr_cmd);
        clr_cmd = 1; prog_fail = 1; step(2);
        // R3 suspend/resume and collisions
        pulse(eng_start); pulse(susp_ack); pulse(resume);
        susp_ack = 1; resume = 1; step();
        eng_start = 1; susp_ack = 1; step();
        pulse(clr_cmd);
        pulse(resume); pulse(eng_done);
        // R8 long access with changes inside
        cs_n = 0; rd_n = 0; step();
        pulse(eng_start); pulse(erase_fail); step(3);
        rd_n = 1; step(2);             // R7 tracking again
        rd_n = 0; step(); pulse(eng_done); cs_n = 1; step(); cs_n = 0; step(3);
        cs_n = 1; rd_n = 1;
        pulse(clr_cmd);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            eng_start  = (r[3:0] == 0);
            eng_done   = (r[7:4] == 1);
            susp_ack   = (r[11:8] == 2);
            resume     = (r[15:12] == 3);
            erase_fail = (r[19:16] == 4);
            prog_fail  = (r[23:20] == 5);
            vpp_low    = (r[27:24] == 6);
            clr_cmd    = (r[30:28] == 7);
            if (r[31]) begin cs_n = ($urandom_range(0, 7) == 0); rd_n = ($urandom_range(0, 7) == 0); end
            step();
        end
        step(2);
        done_f = 1;
    end

    initial begin
        fork
            wait (done_f);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule